// File: doc/BRIEF.md
# Controller Interrupt Status Register

This block gathers single-cycle event pulses from a bus controller's transmit, receive, power-mode and error logic and holds each one in a sticky status bit with a fixed position. Software reads the status word. It clears any bit by writing a one to the same position of a separate clear port. Writing zero to the core-enable control bit also wipes the error, power-mode, overflow, timestamp-wrap and receive bits. The transmit-served bit and the watermark bit keep their values.

Two event sources live inside the block. A timestamp counter runs while the core is enabled and reports its wrap from all-ones to zero. A comparator watches the fill level of receive FIFO-0 against a programmed watermark and detects a message lost to a full FIFO. A per-bit enable mask gates the status word onto one interrupt line.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `status`, `irq` and `ts_value` are all zero, and the core is disabled.
- R2: A one-cycle pulse sets its bit one clock later, and the bit then stays set: `ev_txrr_served` sets bit 13, `ev_wake` sets bit 11, `ev_sleep` sets bit 10, `ev_bus_off` sets bit 9, `ev_error` sets bit 8 and `ev_rx_ok` sets bit 4.
- R3: A cycle with `clr_wr` high clears every status bit where `clr_data` is 1 and leaves the others alone. For a pulse-driven bit, a set and a clear in the same cycle leave the bit set.
- R4: A cycle with `core_en_wr` high and `core_en_wdata` low clears bits 11, 10, 9, 8, 6, 5 and 4 and leaves bits 13 and 12 alone. Writing 1 clears nothing.
- R5: Bit 12 sets whenever `rx0_fill` is strictly greater than `rx0_wm`, and it does not set when the two are equal. A clear of bit 12 wins in its own cycle. If the level is still above the watermark, the bit sets again on the next clock.
- R6: Bit 6 sets when `rx0_msg` is high while `rx0_fill` equals FIFO_DEPTH (64 by default). A message at a lower fill does not set it.
- R7: `ts_value` increments by one each clock while the core is enabled and holds while it is disabled. In the clock where it rolls from 0xFFFF to 0x0000, bit 5 sets.
- R8: Bits 15, 14, 7 and 3 to 0 always read 0.
- R9: `irq` is high exactly when some bit is set in both `status` and `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_en_wr | input | 1 | Write strobe for the core-enable bit |
| core_en_wdata | input | 1 | Value written to the core-enable bit |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_data | input | 16 | Write-one-to-clear data |
| irq_mask | input | 16 | Per-bit interrupt enable |
| ev_txrr_served | input | 1 | Transmit buffer-ready request served pulse |
| ev_wake | input | 1 | Sleep-to-normal transition pulse |
| ev_sleep | input | 1 | Sleep entry pulse |
| ev_bus_off | input | 1 | Bus-off entry pulse |
| ev_error | input | 1 | Transfer error pulse |
| ev_rx_ok | input | 1 | Frame received and stored pulse |
| rx0_msg | input | 1 | Message mapped to FIFO-0 arrives |
| rx0_fill | input | FILL_W | FIFO-0 fill level |
| rx0_wm | input | FILL_W | FIFO-0 full watermark |
| status | output | 16 | Status word |
| irq | output | 1 | Masked interrupt |
| ts_value | output | TS_W | Timestamp counter |

## Verification
The timestamp-wrap bit is the hardest case to reach. It needs the core enabled without a break for a full 65536-clock count, and nothing at the ports can preload the counter. The stimulus enables the core and samples `ts_value`. It then idles for exactly the cycles left until the count reaches 0xFFFF and checks that bit 5 is still clear. One clock later it checks that the count is zero and bit 5 is set. After that, a core-disable write must clear bit 5 and freeze the count. The watermark re-set after a clear is driven by holding the fill level above the watermark across the clear cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   localparam int STAT_W = 16;
   localparam int B_TXRR  = 13;
   localparam int B_WM    = 12;
   localparam int B_WAKE  = 11;
   localparam int B_SLEEP = 10;
   localparam int B_BOFF  = 9;
   localparam int B_ERR   = 8;
   localparam int B_OVF   = 6;
   localparam int B_TSW   = 5;
   localparam int B_RXOK  = 4;
   localparam logic [STAT_W-1:0] IMPL_MASK  = 16'h3F70;
   localparam logic [STAT_W-1:0] CEN_MASK   = 16'h0F70;
   localparam logic [STAT_W-1:0] LEVEL_MASK = 16'h1000;
endpackage

// File: rtl/sticky_bit.sv
module sticky_bit #(
   parameter bit LEVEL   = 1'b0,
   parameter bit CEN_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic cen_clr,
   output logic q
);
   logic clr_any;
   logic q_d;

   assign clr_any = clr | (CEN_CLR & cen_clr);

   generate
      if (LEVEL) begin : g_level
         always_comb q_d = set ? ~clr_any : (q & ~clr_any);
      end else begin : g_pulse
         always_comb q_d = set | (q & ~clr_any);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_d;
   end

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q && !clr_any |=> q);
   // R3
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any && (LEVEL || !set) |=> !q);
   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set && (!LEVEL || !clr_any) |=> q);
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   assign wrap = run && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
   end

   // R7
   ts_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && cnt == TOP |=> cnt == '0);
   // R7
   ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));
endmodule

// File: rtl/wm_compare.sv
module wm_compare #(
   parameter int FILL_W = 7,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill,
   input  logic [FILL_W-1:0] wm,
   input  logic              msg,
   output logic              above,
   output logic              lost
);
   assign above = fill > wm;
   assign lost  = msg && (fill == FILL_W'(DEPTH));

   // R6
   fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_stat_pkg::*;
#(
   parameter int TS_W       = 16,
   parameter int FILL_W     = 7,
   parameter int FIFO_DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_en_wr,
   input  logic              core_en_wdata,
   input  logic              clr_wr,
   input  logic [15:0]       clr_data,
   input  logic [15:0]       irq_mask,
   input  logic              ev_txrr_served,
   input  logic              ev_wake,
   input  logic              ev_sleep,
   input  logic              ev_bus_off,
   input  logic              ev_error,
   input  logic              ev_rx_ok,
   input  logic              rx0_msg,
   input  logic [FILL_W-1:0] rx0_fill,
   input  logic [FILL_W-1:0] rx0_wm,
   output logic [15:0]       status,
   output logic              irq,
   output logic [TS_W-1:0]   ts_value
);
   if (FIFO_DEPTH >= 2**FILL_W) begin : g_bad_depth
      $error("FIFO_DEPTH does not fit in FILL_W bits");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("TS_W must be at least 2");
   end

   logic              core_en_q;
   logic              cen_clr;
   logic              ts_wrap;
   logic              wm_above;
   logic              ovf_lost;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic              unused_bits;

   assign cen_clr = core_en_wr && !core_en_wdata;
   assign clr_vec = clr_wr ? clr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          core_en_q <= 1'b0;
      else if (core_en_wr) core_en_q <= core_en_wdata;
   end

   ts_counter #(.W(TS_W)) u_ts (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (core_en_q),
      .cnt  (ts_value),
      .wrap (ts_wrap)
   );

   wm_compare #(.FILL_W(FILL_W), .DEPTH(FIFO_DEPTH)) u_wm (
      .clk  (clk),
      .rst_n(rst_n),
      .fill (rx0_fill),
      .wm   (rx0_wm),
      .msg  (rx0_msg),
      .above(wm_above),
      .lost (ovf_lost)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[B_TXRR]  = ev_txrr_served;
      set_vec[B_WM]    = wm_above;
      set_vec[B_WAKE]  = ev_wake;
      set_vec[B_SLEEP] = ev_sleep;
      set_vec[B_BOFF]  = ev_bus_off;
      set_vec[B_ERR]   = ev_error;
      set_vec[B_OVF]   = ovf_lost;
      set_vec[B_TSW]   = ts_wrap;
      set_vec[B_RXOK]  = ev_rx_ok;
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         sticky_bit #(.LEVEL(LEVEL_MASK[i]), .CEN_CLR(CEN_MASK[i])) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (set_vec[i]),
            .clr    (clr_vec[i]),
            .cen_clr(cen_clr),
            .q      (status[i])
         );
      end else begin : g_tie
         assign status[i] = 1'b0;
      end
   end

   assign unused_bits = ^((clr_vec | set_vec) & ~IMPL_MASK);
   assign irq = |(status & irq_mask);

   // R7
   ts_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_wrap |=> status[B_TSW]);
   // R5
   wm_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wm_above && !clr_vec[B_WM] |=> status[B_WM]);
   // R4
   cen_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_clr && ((set_vec & CEN_MASK) == '0) |=> (status & CEN_MASK) == '0);
   // R4
   cen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_clr && !clr_vec[B_TXRR] && status[B_TXRR] |=> status[B_TXRR]);
endmodule

// File: tb/test_irq_status_reg.sv
`timescale 1ns/1ps
module test_irq_status_reg;
   localparam logic [15:0] IMPL = 16'h3F70;
   localparam logic [15:0] CENM = 16'h0F70;

   typedef struct {
      string       tag;
      logic [15:0] st;
      logic        irq;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_en_wr = 0, core_en_wdata = 0, clr_wr = 0;
   logic [15:0] clr_data = '0, irq_mask = '0;
   logic ev_txrr = 0, ev_wake = 0, ev_sleep = 0, ev_boff = 0, ev_err = 0, ev_rxok = 0;
   logic rx0_msg = 0;
   logic [6:0] rx0_fill = '0, rx0_wm = 7'd40;
   logic [15:0] status, ts_value;
   logic irq;

   int n_cmp = 0, n_bad = 0;
   logic [15:0] exp_stat = '0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   irq_status_reg i_irq_status_reg (
      .clk(clk), .rst_n(rst_n), .core_en_wr(core_en_wr), .core_en_wdata(core_en_wdata),
      .clr_wr(clr_wr), .clr_data(clr_data), .irq_mask(irq_mask),
      .ev_txrr_served(ev_txrr), .ev_wake(ev_wake), .ev_sleep(ev_sleep),
      .ev_bus_off(ev_boff), .ev_error(ev_err), .ev_rx_ok(ev_rxok),
      .rx0_msg(rx0_msg), .rx0_fill(rx0_fill), .rx0_wm(rx0_wm),
      .status(status), .irq(irq), .ts_value(ts_value)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // driver: one stimulus cycle, expected result pushed to the scoreboard
   task automatic tick(string tag);
      logic [15:0] sets, clrm, nxt;
      logic lvl;
      exp_t it;
      lvl = rx0_fill > rx0_wm;
      sets = '0;
      sets[13] = ev_txrr; sets[11] = ev_wake; sets[10] = ev_sleep;
      sets[9] = ev_boff;  sets[8] = ev_err;   sets[4] = ev_rxok;
      sets[6] = rx0_msg && (rx0_fill == 7'd64);
      clrm = clr_wr ? clr_data : '0;
      if (core_en_wr && !core_en_wdata) clrm = clrm | CENM;
      nxt = (exp_stat & ~clrm) | sets;
      nxt[12] = lvl ? ~clrm[12] : (exp_stat[12] & ~clrm[12]);
      exp_stat = nxt & IMPL;
      it.tag = tag; it.st = exp_stat; it.irq = |(exp_stat & irq_mask);
      exp_q.push_back(it);
      @(negedge clk);
      {ev_txrr, ev_wake, ev_sleep, ev_boff, ev_err, ev_rxok, rx0_msg} = '0;
      clr_wr = 0; clr_data = '0; core_en_wr = 0;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check({it.tag, " status"}, {16'h0, status}, {16'h0, it.st});
            check({it.tag, " irq"}, {31'h0, irq}, {31'h0, it.irq});
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1
      check("R1 status", {16'h0, status}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 ts", {16'h0, ts_value}, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // R2 / R8 pulses, each in turn
      ev_txrr = 1; tick("R2 txrr bit13");
      ev_wake = 1; tick("R2 wake bit11");
      ev_sleep = 1; ev_boff = 1; tick("R2 sleep+busoff");
      ev_err = 1; ev_rxok = 1; tick("R2 error+rxok");
      tick("R2 hold");
      // R9
      irq_mask = 16'h0010; tick("R9 mask rxok");
      irq_mask = 16'hC08F; tick("R9 mask unused bits R8");
      // R3 clear, leave others
      clr_wr = 1; clr_data = 16'h0900; tick("R3 clear 11,8");
      clr_wr = 1; clr_data = 16'hFFFF; ev_wake = 1; tick("R3 set wins");
      clr_wr = 1; clr_data = 16'hFFFF; tick("R3 clear all");
      // R6
      rx0_wm = 7'd64; rx0_fill = 7'd63; rx0_msg = 1; tick("R6 not full");
      rx0_fill = 7'd64; rx0_msg = 1; tick("R6 lost msg");
      // R5
      rx0_wm = 7'd20; rx0_fill = 7'd20; tick("R5 equal no set");
      rx0_fill = 7'd21; tick("R5 above sets");
      irq_mask = 16'h1000;
      clr_wr = 1; clr_data = 16'h1000; tick("R5 clear one cycle");
      tick("R5 sets again");
      rx0_fill = 7'd5; clr_wr = 1; clr_data = 16'h1000; tick("R5 cleared below");
      rx0_fill = 7'd30; tick("R5 set for R4");
      rx0_fill = 7'd5;
      // R4
      ev_txrr = 1; ev_boff = 1; ev_rxok = 1; rx0_msg = 1; rx0_fill = 7'd64; rx0_wm = 7'd64;
      tick("R4 load");
      core_en_wr = 1; core_en_wdata = 0; tick("R4 disable wipe");
      core_en_wr = 1; core_en_wdata = 1; ev_err = 1; tick("R4 enable keeps");
      irq_mask = 16'hFFFF; tick("R9 all");

      // R7 timestamp wrap
      clr_wr = 1; clr_data = 16'hFFFF; rx0_fill = 7'd0; tick("R7 prep");
      repeat (2) @(negedge clk);
      v = ts_value;
      repeat (16'hFFFF - v) @(negedge clk);
      check("R7 at top", {16'h0, ts_value}, 32'h0000FFFF);
      check("R7 no flag yet", {31'h0, status[5]}, 32'h0);
      @(negedge clk);
      check("R7 rolled", {16'h0, ts_value}, 32'h0);
      check("R7 wrap flag", {31'h0, status[5]}, 32'h1);
      exp_stat[5] = 1'b1;
      core_en_wr = 1; core_en_wdata = 0; tick("R4 disable clears bit5");
      v = ts_value;
      repeat (5) @(negedge clk);
      check("R7 hold when off", {16'h0, ts_value}, {16'h0, v});
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule